// File: doc/BRIEF.md
# Resistive crossbar cell access sequencer

This block converts single-cycle read and write requests into the timed control phases needed by a bistable resistive crosspoint cell. Software-invisible and purely sequential, it produces the write-enable level, a two-bit polarity code for the selected word and bit lines, a control that biases the unselected lines, and the sense-amplifier enable. The cell array, the line drivers and the sense amplifier sit outside the block.

A write holds one bias polarity for a programmed number of cycles. A 1 uses positive polarity, with the selected word line at the write level and the bit line grounded. A 0 uses the opposite polarity. A read runs in two halves of equal programmed length. The first half applies negative read bias, which disturbs the cell. The second half applies positive read bias, which restores a stored 1. Sensing happens only in the second half, and the sensed bit is registered and presented together with a one-cycle done pulse. For defect screening, a test-mode input allows a shortened weak write whose length comes from an input port.

Top module: `xbar_seq`

## Requirements
- R1: While reset is asserted and right after it, wr_en=0, bias_sel=2'b00, unsel_iso=0, sense_en=0, busy=0, done=0, err=0 and rdata=0.
- R2: A write accepted at a clock edge drives wr_en=1 for exactly W_CYC cycles, starting in the next cycle. During those cycles bias_sel is 2'b01 (positive) when the data bit is 1 and 2'b10 (negative) when it is 0.
- R3: unsel_iso is 1 in every write cycle and 0 in every read, done and idle cycle.
- R4: A read accepted at a clock edge drives wr_en=0 with bias_sel=2'b10 for R_CYC cycles, then bias_sel=2'b01 for R_CYC cycles. The second half always runs in full, so a stored 1 is left restored.
- R5: sense_en is 1 in exactly the R_CYC cycles of the second read half, and 0 at all other times.
- R6: rdata takes the value of sense_in at the last cycle of the second read half. It is valid during the done pulse and holds until the next read completes. Writes leave it unchanged.
- R7: done is a single-cycle pulse in the cycle after the last write or read cycle. bias_sel is 2'b00 (floating) during done and whenever the block is idle.
- R8: busy is 1 from the cycle after a request is accepted up to and including the done cycle. A request is accepted only when busy is 0.
- R9: A request that arrives while busy is 1, including during the done cycle, is ignored and raises err for exactly the next cycle.
- R10: With test_mode=1 at acceptance, a write lasts weak_cycles cycles, clamped to the range 1 to W_CYC. With test_mode=0, weak_cycles has no effect and the write lasts W_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_wdata | input | 1 | Bit to store on a write |
| test_mode | input | 1 | Selects a weak (shortened) write |
| weak_cycles | input | CW | Weak write length in cycles |
| sense_in | input | 1 | Sensed bit from the sense amplifier |
| wr_en | output | 1 | Write-enable level (1 write, 0 read) |
| bias_sel | output | 2 | Selected-line polarity: 01 positive, 10 negative, 00 floating |
| unsel_iso | output | 1 | Bias the unselected lines to block stray voltage |
| sense_en | output | 1 | Sense-amplifier enable |
| rdata | output | 1 | Registered read result |
| done | output | 1 | Operation-complete pulse |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Request rejected while busy |

## Verification
A wrong phase or a wrong cycle count inside the sequencer shows up at the ports within one cycle: bias_sel, wr_en and sense_en are decoded straight from the phase, so a slip of the timer moves a polarity edge or the done pulse by at least one cycle. A wrongly captured read bit first appears in rdata at the done pulse. A lost restore half appears in the cell model as a disturbed cell that was never returned to its state. The bench therefore compares every output against a behavioural model on every cycle, so any divergence is caught in the cycle where it appears.

// File: rtl/xbar_seq_pkg.sv
package xbar_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_WR   = 3'd1,
      PH_RD1  = 3'd2,
      PH_RD2  = 3'd3,
      PH_DONE = 3'd4
   } phase_t;

   localparam logic [1:0] BIAS_FLOAT = 2'b00;
   localparam logic [1:0] BIAS_POS   = 2'b01;
   localparam logic [1:0] BIAS_NEG   = 2'b10;

   function automatic int cnt_width(input int a, input int b);
      int m;
      m = (a > b) ? a : b;
      return $clog2(m + 1);
   endfunction

endpackage

// File: rtl/xbar_seq_dur.sv
module xbar_seq_dur #(
   parameter int W_CYC        = 6,
   parameter int R_CYC        = 3,
   parameter bit TEST_WEAK_EN = 1'b1,
   parameter int CW           = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          test_mode,
   input  logic [CW-1:0] weak_cycles,
   output logic [CW-1:0] wr_len,
   output logic [CW-1:0] rd_len
);

   localparam logic [CW-1:0] WR_INIT = CW'(W_CYC);
   localparam logic [CW-1:0] RD_INIT = CW'(R_CYC);

   logic [CW-1:0] cfg_wr;
   logic [CW-1:0] cfg_rd;

   // duration registers, loaded at reset and held afterwards
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_wr <= WR_INIT;
         cfg_rd <= RD_INIT;
      end else begin
         cfg_wr <= cfg_wr;
         cfg_rd <= cfg_rd;
      end
   end

   assign rd_len = cfg_rd;

   generate
      if (TEST_WEAK_EN) begin : g_weak
         logic [CW-1:0] weak_len;
         always_comb begin
            if (weak_cycles == '0)
               weak_len = CW'(1);
            else if (weak_cycles > cfg_wr)
               weak_len = cfg_wr;
            else
               weak_len = weak_cycles;
         end
         assign wr_len = test_mode ? weak_len : cfg_wr;
      end else begin : g_full
         assign wr_len = cfg_wr;
      end
   endgenerate

   AST_WR_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_len != '0) && (wr_len <= cfg_wr)); // R10
   AST_FULL_NO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> (wr_len == WR_INIT)); // R10

endmodule

// File: rtl/xbar_seq_fsm.sv
module xbar_seq_fsm
   import xbar_seq_pkg::*;
#(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_wdata,
   input  logic [CW-1:0] wr_len,
   input  logic [CW-1:0] rd_len,
   output phase_t        phase,
   output logic          wbit,
   output logic          last,
   output logic          err
);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_n;
   phase_t        nxt;
   logic          accept;

   assign last   = (cnt == '0);
   assign accept = req_valid && (phase == PH_IDLE);

   always_comb begin
      nxt   = phase;
      cnt_n = cnt;
      unique case (phase)
         PH_IDLE: begin
            if (req_valid) begin
               nxt   = req_write ? PH_WR : PH_RD1;
               cnt_n = (req_write ? wr_len : rd_len) - 1'b1;
            end
         end
         PH_WR: begin
            if (last) nxt = PH_DONE;
            else      cnt_n = cnt - 1'b1;
         end
         PH_RD1: begin
            if (last) begin
               nxt   = PH_RD2;
               cnt_n = rd_len - 1'b1;
            end else begin
               cnt_n = cnt - 1'b1;
            end
         end
         PH_RD2: begin
            if (last) nxt = PH_DONE;
            else      cnt_n = cnt - 1'b1;
         end
         PH_DONE: nxt = PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         wbit  <= 1'b0;
         err   <= 1'b0;
      end else begin
         phase <= nxt;
         cnt   <= cnt_n;
         err   <= req_valid && (phase != PH_IDLE);
         if (accept && req_write) wbit <= req_wdata;
      end
   end

   AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (phase == PH_WR) || (phase == PH_RD1)); // R8
   AST_HALF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RD1) && last |=> (phase == PH_RD2)); // R4
   AST_NO_SKIP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RD1) |=> (phase == PH_RD1) || (phase == PH_RD2)); // R4

endmodule

// File: rtl/xbar_seq_drive.sv
module xbar_seq_drive
   import xbar_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  phase_t     phase,
   input  logic       wbit,
   output logic       wr_en,
   output logic [1:0] bias_sel,
   output logic       unsel_iso,
   output logic       sense_en,
   output logic       busy,
   output logic       done
);

   always_comb begin
      wr_en     = 1'b0;
      bias_sel  = BIAS_FLOAT;
      unsel_iso = 1'b0;
      sense_en  = 1'b0;
      busy      = 1'b1;
      done      = 1'b0;
      unique case (phase)
         PH_IDLE: busy = 1'b0;
         PH_WR: begin
            wr_en     = 1'b1;
            bias_sel  = wbit ? BIAS_POS : BIAS_NEG;
            unsel_iso = 1'b1;
         end
         PH_RD1: bias_sel = BIAS_NEG;
         PH_RD2: begin
            bias_sel = BIAS_POS;
            sense_en = 1'b1;
         end
         PH_DONE: done = 1'b1;
         default: busy = 1'b0;
      endcase
   end

   AST_SENSE_POS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      sense_en |-> (bias_sel == BIAS_POS) && !wr_en); // R5
   AST_SENSE_AFTER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sense_en) |-> ($past(bias_sel) == BIAS_NEG)); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy); // R7
   AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy || done) |-> (bias_sel == BIAS_FLOAT)); // R7
   AST_ISO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      unsel_iso |-> wr_en && (bias_sel != BIAS_FLOAT)); // R3

endmodule

// File: rtl/xbar_seq_capture.sv
module xbar_seq_capture (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic sense_in,
   output logic rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= 1'b0;
      else if (capture) rdata <= sense_in;
   end

endmodule

// File: rtl/xbar_seq.sv
module xbar_seq
   import xbar_seq_pkg::*;
#(
   parameter int W_CYC        = 6,
   parameter int R_CYC        = 3,
   parameter bit TEST_WEAK_EN = 1'b1,
   localparam int CW          = cnt_width(W_CYC, R_CYC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_wdata,
   input  logic          test_mode,
   input  logic [CW-1:0] weak_cycles,
   input  logic          sense_in,
   output logic          wr_en,
   output logic [1:0]    bias_sel,
   output logic          unsel_iso,
   output logic          sense_en,
   output logic          rdata,
   output logic          done,
   output logic          busy,
   output logic          err
);

   generate
      if (W_CYC < 1) begin : g_bad_w
         $error("xbar_seq: W_CYC must be at least 1");
      end
      if (R_CYC < 1) begin : g_bad_r
         $error("xbar_seq: R_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] wr_len;
   logic [CW-1:0] rd_len;
   phase_t        phase;
   logic          wbit;
   logic          last;

   xbar_seq_dur #(
      .W_CYC(W_CYC), .R_CYC(R_CYC), .TEST_WEAK_EN(TEST_WEAK_EN), .CW(CW)
   ) u_dur (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
      .weak_cycles(weak_cycles), .wr_len(wr_len), .rd_len(rd_len)
   );

   xbar_seq_fsm #(.CW(CW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wdata(req_wdata), .wr_len(wr_len), .rd_len(rd_len),
      .phase(phase), .wbit(wbit), .last(last), .err(err)
   );

   xbar_seq_drive u_drive (
      .clk(clk), .rst_n(rst_n), .phase(phase), .wbit(wbit),
      .wr_en(wr_en), .bias_sel(bias_sel), .unsel_iso(unsel_iso),
      .sense_en(sense_en), .busy(busy), .done(done)
   );

   xbar_seq_capture u_cap (
      .clk(clk), .rst_n(rst_n), .capture((phase == PH_RD2) && last),
      .sense_in(sense_in), .rdata(rdata)
   );

   AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(busy)); // R9
   AST_ERR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done && req_valid |=> busy); // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_en |=> $stable(rdata)); // R6

endmodule

// File: tb/xbar_seq_test.sv
module xbar_seq_test;

   localparam int W_CYC = 6;
   localparam int R_CYC = 3;
   localparam int CW    = $clog2(((W_CYC > R_CYC) ? W_CYC : R_CYC) + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic          req_wdata = 1'b0;
   logic          test_mode = 1'b0;
   logic [CW-1:0] weak_cycles = '0;
   logic          sense_in;
   logic          wr_en, unsel_iso, sense_en, rdata, done, busy, err;
   logic [1:0]    bias_sel;

   always #10 clk = ~clk;

   xbar_seq #(.W_CYC(W_CYC), .R_CYC(R_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wdata(req_wdata), .test_mode(test_mode), .weak_cycles(weak_cycles),
      .sense_in(sense_in), .wr_en(wr_en), .bias_sel(bias_sel),
      .unsel_iso(unsel_iso), .sense_en(sense_en), .rdata(rdata),
      .done(done), .busy(busy), .err(err)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // behavioural cell: bit, disturbance flag, write run length
   bit cell_bit = 0;
   bit disturbed = 0;
   int wr_run = 0;
   bit wr_pol = 0;
   int last_wr_len = 0;

   assign sense_in = sense_en & cell_bit & ~disturbed;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en && bias_sel != 2'b00) begin
            wr_run++;
            wr_pol = (bias_sel == 2'b01);
         end else if (wr_run > 0) begin
            if (wr_run >= W_CYC) cell_bit = wr_pol;
            last_wr_len = wr_run;
            wr_run = 0;
         end
         if (!wr_en && bias_sel == 2'b10 && cell_bit) disturbed = 1;
         if (!wr_en && bias_sel == 2'b01) disturbed = 0;
      end
   end

   // reference model: 0 idle, 1 write, 2 first half, 3 second half, 4 done
   int m_ph, m_left;
   bit m_wbit, m_err, m_rdata;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_wbit = 0; m_err = 0; m_rdata = 0;
      end else begin
         m_err = req_valid && (m_ph != 0);
         case (m_ph)
            0: if (req_valid) begin
                  if (req_write) begin
                     m_ph = 1;
                     m_wbit = req_wdata;
                     if (!test_mode)             m_left = W_CYC;
                     else if (weak_cycles == 0)  m_left = 1;
                     else if (int'(weak_cycles) > W_CYC) m_left = W_CYC;
                     else                        m_left = int'(weak_cycles);
                  end else begin
                     m_ph = 2;
                     m_left = R_CYC;
                  end
               end
            1: begin m_left--; if (m_left == 0) m_ph = 4; end
            2: begin m_left--; if (m_left == 0) begin m_ph = 3; m_left = R_CYC; end end
            3: begin m_left--; if (m_left == 0) begin m_ph = 4; m_rdata = cell_bit; end end
            default: m_ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int e_bias;
         e_bias = (m_ph == 1) ? (m_wbit ? 1 : 2) : (m_ph == 2) ? 2 : (m_ph == 3) ? 1 : 0;
         chk(wr_en == (m_ph == 1), "R2 wr_en", wr_en, m_ph == 1);
         chk(bias_sel == e_bias, "R4 bias_sel", bias_sel, e_bias);
         chk(unsel_iso == (m_ph == 1), "R3 unsel_iso", unsel_iso, m_ph == 1);
         chk(sense_en == (m_ph == 3), "R5 sense_en", sense_en, m_ph == 3);
         chk(busy == (m_ph != 0), "R8 busy", busy, m_ph != 0);
         chk(done == (m_ph == 4), "R7 done", done, m_ph == 4);
         chk(err == m_err, "R9 err", err, m_err);
         chk(rdata == m_rdata, "R6 rdata", rdata, m_rdata);
      end
   end

   task automatic wait_idle();
      while (m_ph != 0) @(negedge clk);
   endtask

   task automatic issue(input bit w, input bit d, input bit tm, input int wk);
      @(negedge clk);
      req_valid = 1; req_write = w; req_wdata = d; test_mode = tm;
      weak_cycles = CW'(wk);
      @(negedge clk);
      req_valid = 0; test_mode = 0; weak_cycles = '0;
      wait_idle();
   endtask

   task automatic read_expect(input bit exp, input string tag);
      issue(0, 0, 0, 0);
      chk(rdata == exp, tag, rdata, exp);
      chk(disturbed == 0, "R4 restore left cell undisturbed", disturbed, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({wr_en, bias_sel, unsel_iso, sense_en, busy, done, err, rdata} == 0,
          "R1 reset outputs", {wr_en, bias_sel, unsel_iso, sense_en, busy, done, err, rdata}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0 && bias_sel == 0, "R1 idle after reset", {busy, bias_sel}, 0);

      issue(1, 1, 0, 0);
      chk(last_wr_len == W_CYC, "R2 write length", last_wr_len, W_CYC);
      read_expect(1, "R6 read after write 1");
      read_expect(1, "R4 second read of 1 after restore");
      issue(1, 0, 0, 0);
      read_expect(0, "R6 read after write 0");
      issue(1, 1, 0, 5);
      chk(last_wr_len == W_CYC, "R10 weak_cycles ignored without test_mode", last_wr_len, W_CYC);

      // weak writes
      issue(1, 0, 1, 2);
      chk(last_wr_len == 2, "R10 weak write length", last_wr_len, 2);
      read_expect(1, "R10 weak write leaves cell");
      issue(1, 0, 1, 0);
      chk(last_wr_len == 1, "R10 clamp low", last_wr_len, 1);
      issue(1, 0, 1, 7);
      chk(last_wr_len == W_CYC, "R10 clamp high", last_wr_len, W_CYC);
      read_expect(0, "R10 clamped full write takes effect");

      // request during busy: ignored
      @(negedge clk);
      req_valid = 1; req_write = 0;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_wdata = 1;
      @(negedge clk);
      req_valid = 0;
      chk(err == 1, "R9 err after busy request", err, 1);
      wait_idle();
      read_expect(0, "R9 ignored write did not land");

      // request during done cycle, then back-to-back from idle
      @(negedge clk);
      req_valid = 1; req_write = 1; req_wdata = 1;
      @(negedge clk);
      req_valid = 0;
      while (m_ph != 4) @(negedge clk);
      req_valid = 1; req_write = 1; req_wdata = 0;
      @(negedge clk);
      req_valid = 0;
      chk(err == 1 && busy == 0, "R9 done-cycle request ignored", {err, busy}, 2);
      req_valid = 1; req_write = 0;
      @(negedge clk);
      req_valid = 0;
      wait_idle();
      chk(rdata == 1, "R6 back-to-back read", rdata, 1);
      issue(1, 0, 0, 0);
      chk(rdata == 1, "R6 rdata held across write", rdata, 1);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule